// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. It watches an oversampled two-wire bus (a clock line and an open-drain data line), finds start, repeated-start and stop conditions, and compares each select byte against a fixed type code and three strap inputs. After a write-direction select it takes a two-byte memory address and then data bytes. It hands each accepted data byte to the write-commit logic as a one-cycle strobe with address and data. After a read-direction select it shifts bytes out of the memory array, which is reached through a registered read port.

A single address pointer serves current-address, random and sequential reads and steps through a page during writes. A busy input from the write-commit logic makes the engine refuse every select while an internal write cycle runs, so a master can poll on the acknowledge. A write-protect input refuses data bytes but still acknowledges select and address bytes.

Top module: `sermem_slave`

## Requirements
- R1: A select byte arrives MSB first. It is acknowledged (data line pulled low through the whole 9th clock) only when bits 7..4 equal 1010 and bits 3..1 equal `dev_strap[2:0]`. Bit 0 selects the direction: 1 means read, 0 means write.
- R2: A select byte that does not match gets no acknowledge. The engine then ignores the bus until the next start, and further bytes are not acknowledged.
- R3: After a write-direction select, two address bytes (high byte first) are each acknowledged. Each data byte is acknowledged and produces exactly one `mem_we` pulse carrying the pointer address and the byte.
- R4: While `wr_prot` is high, select and address bytes are still acknowledged, but every data byte gets no acknowledge and no `mem_we` pulse, so memory keeps its contents.
- R5: After each written byte, only the low PAGE_W (default 6) pointer bits increment, wrapping within the page. The upper bits stay unchanged.
- R6: A random read (write select, two address bytes, repeated start, read select) returns the byte at the loaded address. Address bits above ADDR_W (default 15) are ignored.
- R7: A read select with no preceding address returns the byte at the current pointer, and the pointer then increments.
- R8: In a read, a master acknowledge makes the next byte come out. The pointer wraps from the last location (all ones) to address 0.
- R9: If the master gives no acknowledge after a read byte, the engine stops driving and stays silent even if clocks continue without a stop.
- R10: While `wr_busy` is high, even a matching select gets no acknowledge.
- R11: A start seen in the middle of a byte abandons that byte and begins a new select phase.
- R12: The data-line drive changes only while the clock line is low, and it is released during the acknowledge slot after each read byte.
- R13: After reset, and after a stop, the engine is idle. It does not drive the line, and it acknowledges no byte until a start is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_strap | input | 3 | Strap value compared with select bits 3..1 |
| wr_prot | input | 1 | 1 refuses data bytes of writes |
| wr_busy | input | 1 | 1 while an internal write cycle runs; all selects refused |
| mem_addr | output | ADDR_W | Address pointer to the memory array |
| mem_rdata | input | 8 | Array data for `mem_addr`, valid one clock after it changes |
| mem_we | output | 1 | One-cycle strobe for an accepted data byte |
| mem_wdata | output | 8 | Data byte accompanying `mem_we` |

## Verification
A bus edge reaches the phase machine three system-clock edges after it appears on the pins: two synchronizer flops, then the edge register. Acknowledge drive, read-bit drive and `mem_we` therefore change three clocks after the clock-line falling edge that closes a bit. The bench's bus master holds each clock phase low or high for at least five system clocks. It samples the data line one clock after raising the clock line and again just before lowering it, so every sample falls well after the design's response is due. Written bytes are checked by a monitor that pops expected address/data pairs from a queue on each strobe. Read data is compared against a reference memory built only from what the master wrote.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RX    = 3'd1,
      PH_RXACK = 3'd2,
      PH_TX    = 3'd3,
      PH_TXACK = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      BK_SEL  = 2'd0,
      BK_AHI  = 2'd1,
      BK_ALO  = 2'd2,
      BK_DATA = 2'd3
   } bkind_t;
endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [CHAIN_W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[CHAIN_W-W-1:0], d};
         end
         assign q = chain[CHAIN_W-1 -: W];
      end
   endgenerate
endmodule

// File: rtl/sermem_cond.sv
module sermem_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign ev_start = scl & scl_p & sda_p & ~sda;
   assign ev_stop  = scl & scl_p & ~sda_p & sda;
   assign ev_rise  = scl & ~scl_p;
   assign ev_fall  = ~scl & scl_p;
endmodule

// File: rtl/sermem_addr.sv
module sermem_addr #(
   parameter int ADDR_W = 15,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_seq,
   input  logic              inc_page,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] page_next;

   generate
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign page_next = ptr + ONE;
      end else begin : g_paged
         localparam logic [PAGE_W-1:0] PONE = PAGE_W'(1);
         assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PONE};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_seq)  ptr <= ptr + ONE;
      else if (inc_page) ptr <= page_next;
   end
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
   import sermem_pkg::*;
#(
   parameter int          ADDR_W      = 15,
   parameter int          PAGE_W      = 6,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [2:0]        dev_strap,
   input  logic              wr_prot,
   input  logic              wr_busy,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              mem_we,
   output logic [7:0]        mem_wdata
);
   localparam logic [3:0] CNT_BYTE = 4'd8;
   localparam logic [3:0] CNT_LAST = 4'd7;
   localparam logic [3:0] CNT_ONE  = 4'd1;

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
         $error("sermem_slave: ADDR_W must lie in 8..16");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page_w
         $error("sermem_slave: PAGE_W must lie in 1..ADDR_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sermem_slave: SYNC_STAGES must be at least 1");
      end
   endgenerate

   // bus sampling and condition detection
   logic [1:0] sync_q;
   logic       scl_s, sda_s;
   logic       ev_start, ev_stop, ev_rise, ev_fall;

   sermem_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (sync_q)
   );
   assign scl_s = sync_q[1];
   assign sda_s = sync_q[0];

   sermem_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_s),
      .sda      (sda_s),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall)
   );

   // phase machine state
   phase_t     phase_q;
   bkind_t     kind_q;
   logic [3:0] cnt_q;
   logic [7:0] rxsr_q, txsr_q, hi_q, wd_q;
   logic       ack_q, rd_q, mack_q, we_q;

   logic              byte_done, sel_match, quiet;
   logic              ld_ptr, tx_load;
   logic [15:0]       addr_full;
   logic [ADDR_W-1:0] ptr;

   assign quiet     = ~ev_start & ~ev_stop;
   assign byte_done = quiet && (phase_q == PH_RX) && ev_fall && (cnt_q == CNT_BYTE);
   assign sel_match = (rxsr_q[7:4] == TYPE_CODE) && (rxsr_q[3:1] == dev_strap) && !wr_busy;
   assign addr_full = {hi_q, rxsr_q};
   assign ld_ptr    = byte_done && (kind_q == BK_ALO);
   assign tx_load   = quiet && ev_fall &&
                      (((phase_q == PH_RXACK) && (kind_q == BK_SEL) && rd_q) ||
                       ((phase_q == PH_TXACK) && mack_q));

   sermem_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ptr),
      .load_val (addr_full[ADDR_W-1:0]),
      .inc_seq  (tx_load),
      .inc_page (we_q),
      .ptr      (ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= BK_SEL;
         cnt_q   <= '0;
         rxsr_q  <= '0;
         txsr_q  <= '1;
         hi_q    <= '0;
         wd_q    <= '0;
         ack_q   <= 1'b0;
         rd_q    <= 1'b0;
         mack_q  <= 1'b0;
         we_q    <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (ev_start) begin
            phase_q <= PH_RX;
            kind_q  <= BK_SEL;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
         end else if (ev_stop) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b0;
         end else begin
            case (phase_q)
               PH_RX: begin
                  if (ev_rise) begin
                     rxsr_q <= {rxsr_q[6:0], sda_s};
                     cnt_q  <= cnt_q + CNT_ONE;
                  end
                  if (byte_done) begin
                     case (kind_q)
                        BK_SEL: begin
                           if (sel_match) begin
                              ack_q   <= 1'b1;
                              rd_q    <= rxsr_q[0];
                              phase_q <= PH_RXACK;
                           end else begin
                              phase_q <= PH_IDLE;
                           end
                        end
                        BK_AHI: begin
                           hi_q    <= rxsr_q;
                           ack_q   <= 1'b1;
                           phase_q <= PH_RXACK;
                        end
                        BK_ALO: begin
                           ack_q   <= 1'b1;
                           phase_q <= PH_RXACK;
                        end
                        default: begin
                           ack_q   <= !wr_prot;
                           we_q    <= !wr_prot;
                           wd_q    <= rxsr_q;
                           phase_q <= PH_RXACK;
                        end
                     endcase
                  end
               end
               PH_RXACK: begin
                  if (ev_fall) begin
                     ack_q <= 1'b0;
                     cnt_q <= '0;
                     if (kind_q == BK_SEL && rd_q) begin
                        phase_q <= PH_TX;
                        txsr_q  <= mem_rdata;
                     end else begin
                        phase_q <= PH_RX;
                        case (kind_q)
                           BK_SEL:  kind_q <= BK_AHI;
                           BK_AHI:  kind_q <= BK_ALO;
                           default: kind_q <= BK_DATA;
                        endcase
                     end
                  end
               end
               PH_TX: begin
                  if (ev_fall) begin
                     if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_TXACK;
                        cnt_q   <= '0;
                     end else begin
                        txsr_q <= {txsr_q[6:0], 1'b1};
                        cnt_q  <= cnt_q + CNT_ONE;
                     end
                  end
               end
               PH_TXACK: begin
                  if (ev_rise) mack_q <= !sda_s;
                  if (ev_fall) begin
                     if (mack_q) begin
                        phase_q <= PH_TX;
                        txsr_q  <= mem_rdata;
                     end else begin
                        phase_q <= PH_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = ((phase_q == PH_RXACK) && ack_q) || ((phase_q == PH_TX) && !txsr_q[7]);
   assign mem_addr  = ptr;
   assign mem_we    = we_q;
   assign mem_wdata = wd_q;
endmodule

// File: rtl/sermem_chk.sv
module sermem_chk
   import sermem_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input phase_t            phase_q,
   input bkind_t            kind_q,
   input logic              sda_oe,
   input logic              mem_we,
   input logic              wr_prot,
   input logic              wr_busy,
   input logic              tx_load,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !$past(wr_prot));                                         // R4

   AST_BUSY_NO_SEL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && phase_q == PH_RXACK && kind_q == BK_SEL) |-> !$past(wr_busy)); // R10

   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);                                        // R12

   AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);                                                 // R3

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !sda_oe);                                   // R2

   AST_SEQ_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && mem_addr == TOP_ADDR) |=> (mem_addr == '0));             // R8
endmodule

bind sermem_slave sermem_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .phase_q  (phase_q),
   .kind_q   (kind_q),
   .sda_oe   (sda_oe),
   .mem_we   (mem_we),
   .wr_prot  (wr_prot),
   .wr_busy  (wr_busy),
   .tx_load  (tx_load),
   .mem_addr (mem_addr)
);

// File: tb/sim_sermem_slave.sv
module sim_sermem_slave;
   localparam int AW   = 15;
   localparam int PW   = 6;
   localparam int Q    = 5;
   localparam int MASK = (1 << AW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          m_scl = 1'b1, m_sda = 1'b1;
   logic [2:0]    strap = 3'b101;
   logic          wr_prot = 1'b0, wr_busy = 1'b0;
   logic          sda_oe, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata = 8'h00, mem_wdata;
   wire           sda_line = m_sda & ~sda_oe;

   sermem_slave #(.ADDR_W(AW), .PAGE_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
      .dev_strap(strap), .wr_prot(wr_prot), .wr_busy(wr_busy), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // array model and independent reference
   logic [7:0] arr  [int];
   logic [7:0] refm [int];
   function automatic logic [7:0] init_val(input int a);
      return a[7:0] ^ a[14:7];
   endfunction
   function automatic logic [7:0] arr_rd(input int a);
      return arr.exists(a) ? arr[a] : init_val(a);
   endfunction
   function automatic logic [7:0] ref_rd(input int a);
      return refm.exists(a) ? refm[a] : init_val(a);
   endfunction

   always @(posedge clk) mem_rdata <= arr_rd(int'(mem_addr));

   // scoreboard of expected writes
   typedef struct { int a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected write strobe", int'(mem_addr), -1);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(int'(mem_addr) == e.a, "R5", "write address", int'(mem_addr), e.a);
            chk(mem_wdata == e.d, "R3", "write data", mem_wdata, e.d);
         end
         arr[int'(mem_addr)] = mem_wdata;
      end
   end

   int exp_ptr = 0;

   // bus master primitives
   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic i2c_start();
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
   endtask
   task automatic i2c_stop();
      m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
   endtask
   task automatic put_bit(input logic b);
      m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
   endtask
   task automatic get_bit(output logic b, output bit stable);
      logic b0;
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(1);
      b0 = sda_line; wq(2*Q-2);
      b = sda_line; stable = (b0 == b); wq(1);
      m_scl = 1'b0; wq(Q);
   endtask
   task automatic write_byte(input logic [7:0] v, output bit ack);
      logic b; bit s;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b, s);
      ack = !b;
   endtask
   task automatic read_byte(input bit give_ack, output logic [7:0] v, output bit stable, output logic oe_ack);
      logic b; bit s;
      stable = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b, s);
         v[i] = b;
         stable &= s;
      end
      m_sda = give_ack ? 1'b0 : 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
      oe_ack = sda_oe; wq(Q); m_scl = 1'b0; wq(Q);
   endtask

   // transactions
   task automatic sel_addr(input int addr);
      bit ack;
      i2c_start();
      write_byte({4'b1010, strap, 1'b0}, ack);
      chk(ack, "R1", "write select ack", ack, 1);
      write_byte(addr[15:8], ack);
      chk(ack, "R3", "address high ack", ack, 1);
      write_byte(addr[7:0], ack);
      chk(ack, "R3", "address low ack", ack, 1);
      exp_ptr = addr & MASK;
   endtask

   task automatic write_run(input int addr, input int n, input logic [7:0] base, input string req);
      bit ack;
      sel_addr(addr);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         int a;
         d = base + 8'(i);
         a = (exp_ptr & ~((1 << PW) - 1)) | ((exp_ptr + 1 * 0 + i) & ((1 << PW) - 1));
         if (!wr_prot) begin
            exp_q.push_back('{a: a, d: d});
            refm[a] = d;
         end
         write_byte(d, ack);
         chk(ack == !wr_prot, req, "data byte ack", ack, !wr_prot);
      end
      if (!wr_prot)
         exp_ptr = (exp_ptr & ~((1 << PW) - 1)) | ((exp_ptr + n) & ((1 << PW) - 1));
      i2c_stop();
      wq(4);
      chk(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
   endtask

   task automatic read_run(input bit random, input int addr, input int n, input string req, input bit do_stop);
      bit ack, st;
      logic [7:0] v;
      logic oe_ack;
      if (random) sel_addr(addr);
      i2c_start();
      write_byte({4'b1010, strap, 1'b1}, ack);
      chk(ack, "R1", "read select ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, v, st, oe_ack);
         chk(v == ref_rd(exp_ptr), req, "read data", v, ref_rd(exp_ptr));
         chk(st && !oe_ack, "R12", "drive stable while high and released in ack slot", {st, oe_ack}, 2);
         exp_ptr = (exp_ptr + 1) & MASK;
      end
      if (do_stop) i2c_stop();
   endtask

   initial begin
      bit ack, s;
      logic b;
      wq(5);
      chk(sda_oe == 1'b0 && mem_we == 1'b0, "R13", "reset idle outputs", {sda_oe, mem_we}, 0);
      rst_n = 1'b1;
      wq(5);

      // R3 byte write, R6 random read
      write_run(16'h1234, 1, 8'hA5, "R3");
      read_run(1'b1, 16'h1234, 1, "R6", 1'b1);
      // R7 current address reads
      read_run(1'b0, 0, 1, "R7", 1'b1);
      read_run(1'b0, 0, 1, "R7", 1'b1);
      // R5 page write with in-page wrap, pointer follows
      write_run(16'h013E, 3, 8'h60, "R5");
      read_run(1'b0, 0, 1, "R5", 1'b1);
      read_run(1'b1, 16'h0100, 3, "R5", 1'b1);
      // R4 write protect
      wr_prot = 1'b1;
      write_run(16'h0200, 2, 8'h11, "R4");
      wr_prot = 1'b0;
      read_run(1'b1, 16'h0200, 2, "R4", 1'b1);
      // R8 wrap at top, upper address bit ignored (R6)
      read_run(1'b1, 16'hFFFF, 3, "R8", 1'b1);
      // R2 strap mismatch, then bus ignored
      i2c_start();
      write_byte({4'b1010, 3'b011, 1'b0}, ack);
      chk(!ack, "R2", "mismatched strap ack", ack, 0);
      write_byte(8'h00, ack);
      chk(!ack, "R2", "byte after mismatch ack", ack, 0);
      i2c_stop();
      // R1 wrong type code
      i2c_start();
      write_byte({4'b1011, strap, 1'b1}, ack);
      chk(!ack, "R1", "wrong type code ack", ack, 0);
      i2c_stop();
      // R10 busy refuses matching select
      wr_busy = 1'b1;
      i2c_start();
      write_byte({4'b1010, strap, 1'b0}, ack);
      chk(!ack, "R10", "select ack while busy", ack, 0);
      i2c_stop();
      wr_busy = 1'b0;
      i2c_start();
      write_byte({4'b1010, strap, 1'b0}, ack);
      chk(ack, "R10", "select ack after busy", ack, 1);
      i2c_stop();
      // R9 no acknowledge then clocks without stop
      read_run(1'b0, 0, 1, "R9", 1'b0);
      begin
         bit quiet = 1'b1;
         for (int i = 0; i < 9; i++) begin
            get_bit(b, s);
            quiet &= (b == 1'b1);
         end
         chk(quiet, "R9", "line silent after master no-ack", quiet, 1);
      end
      i2c_stop();
      // R11 start inside a byte
      i2c_start();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      sel_addr(16'h1234);
      i2c_start();
      write_byte({4'b1010, strap, 1'b1}, ack);
      chk(ack, "R11", "select after aborted byte", ack, 1);
      begin
         logic [7:0] v; bit st; logic oe_ack;
         read_byte(1'b0, v, st, oe_ack);
         chk(v == 8'hA5, "R11", "read after aborted byte", v, 8'hA5);
      end
      i2c_stop();
      // R13 stop leaves engine idle: byte without start refused
      m_scl = 1'b0; wq(Q);
      write_byte({4'b1010, strap, 1'b0}, ack);
      chk(!ack, "R13", "byte without start ack", ack, 0);
      i2c_stop();

      wq(10);
      chk(exp_q.size() == 0, "R3", "writes outstanding at end", exp_q.size(), 0);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule